// File: doc/BRIEF.md
# Word-to-Byte Fixed-Length Packetizer

This block takes a list of 32-bit result words that a producer has written into an internal bin memory from the sample clock domain. It sends them out as a stream of bytes on an 8-bit AXI-Stream master in a separate, asynchronous network clock domain. The stream is cut into packets of a fixed length, 1024 bytes by default, which is 256 words. The last packet is padded with zero bytes so that it has the same length as the others.

A transfer begins with a one-cycle start pulse in the sample domain. The word count given with that pulse is captured, and the start event crosses into the network domain. Before each packet, the network-side control raises a send request and waits until the consumer answers with ready. Only then does it stream the packet, one byte per handshake, least significant byte of each word first. After the final byte of the final packet, a completion event crosses back to the sample domain and appears there as a one-cycle pulse. Writes to the memory are expected only while no transfer is running.

Top module: `byte_packetizer`

## Requirements
- R1: While either reset is held, and right after it is released, `mTvalid`, `mTlast` and `sendReq` are low and `allSent` is low.
- R2: A transfer of N words (0 to DEPTH) sends ceil(N/256) packets. Every packet has exactly 1024 accepted bytes, including the last one.
- R3: `mTlast` is high on the 1024th byte of every packet and on no other byte.
- R4: Word w goes out in packet w/256 at byte offsets 4*(w mod 256) through 4*(w mod 256)+3. Offset +k carries bits [8k+7:8k] of the word, so the least significant byte comes first.
- R5: Every byte after the last valid word of the final packet is 8'h00.
- R6: A byte moves forward only on a cycle where `mTvalid` and `mTready` are both high. While `mTvalid` is high and `mTready` is low, `mTvalid`, `mTdata` and `mTlast` do not change.
- R7: `sendReq` rises before each packet and stays high until `reqReady` is seen high. No byte of that packet is valid before this happens, and `sendReq` is low while bytes are being offered.
- R8: After the last byte of the final packet is accepted, `allSent` pulses high for exactly one sample clock cycle, once per accepted start.
- R9: A start with a word count of 0 sends no packet and never raises `sendReq`, but `allSent` still pulses.
- R10: A `startPulse` that arrives while a transfer is running is ignored. A transfer runs from the accepted start until its `allSent` pulse.
- R11: `wordCount` is sampled only in the cycle of an accepted `startPulse`. Later changes to it have no effect on the running transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sampleClk | input | 1 | Sample domain clock |
| sampleRst | input | 1 | Synchronous active-high reset, sample domain |
| wrEn | input | 1 | Bin memory write enable |
| wrAddr | input | ADDR_W (10) | Bin memory write address |
| wrData | input | WORD_W (32) | Bin memory write data |
| startPulse | input | 1 | One-cycle request to begin a transfer |
| wordCount | input | ADDR_W+1 (11) | Number of valid words, captured with the start |
| allSent | output | 1 | One-cycle completion pulse, sample domain |
| netClk | input | 1 | Network domain clock |
| netRst | input | 1 | Synchronous active-high reset, network domain |
| sendReq | output | 1 | Packet send request toward the consumer |
| reqReady | input | 1 | Consumer acknowledge of the send request |
| mTdata | output | 8 | Stream byte |
| mTvalid | output | 1 | Stream byte valid |
| mTready | input | 1 | Stream backpressure |
| mTlast | output | 1 | Last byte of a packet |

## Verification
A vector table runs the packetizer with word counts of exactly one packet, a single word, a partial second packet, a third packet with only one word in it, and the whole memory. Each count is paired with its own `mTready` pattern and its own request-to-ready delay. The exact-multiple counts show whether extra packets or stray padding appear. The counts just past a boundary check the packet count rounding and the zero padding. The irregular ready patterns show whether bytes are lost or repeated under stall. Directed runs then cover a zero count, a second start during a transfer, and a count changed after the start.

// File: rtl/bpk_pkg.sv
`timescale 1ns/1ps
package bpk_pkg;
  typedef struct packed {
    logic load;
    logic advance;
  } bpkStrobe_t;

  typedef struct packed {
    logic lastByte;
    logic lastPkt;
    logic noWords;
  } bpkStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_SEND,
    ST_FIN
  } bpkState_t;
endpackage

// File: rtl/bpk_toggle_sync.sv
`timescale 1ns/1ps
module bpk_toggle_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic dstClk,
  input  logic dstRst,
  input  logic srcTog,
  output logic edgePulse
);
  logic [SYNC_STAGES:0] pipe;

  always_ff @(posedge dstClk) begin
    if (dstRst) pipe <= '0;
    else        pipe <= {pipe[SYNC_STAGES-1:0], srcTog};
  end

  assign edgePulse = pipe[SYNC_STAGES] ^ pipe[SYNC_STAGES-1];
endmodule

// File: rtl/bpk_datapath.sv
`timescale 1ns/1ps
module bpk_datapath
  import bpk_pkg::*;
#(
  parameter int WORD_W    = 32,
  parameter int PKT_BYTES = 1024,
  parameter int DEPTH     = 1024,
  localparam int ADDR_W   = $clog2(DEPTH),
  localparam int CNT_W    = ADDR_W + 1
) (
  input  logic              sampleClk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              netClk,
  input  logic              netRst,
  input  bpkStrobe_t        strobe,
  input  logic [CNT_W-1:0]  cfgCount,
  output bpkStatus_t        status,
  output logic [7:0]        byteOut
);
  localparam int BYTES_PER_WORD = WORD_W / 8;
  localparam int LANE_W         = $clog2(BYTES_PER_WORD);
  localparam int BYTE_IDX_W     = $clog2(PKT_BYTES);
  localparam int WORDS_PER_PKT  = PKT_BYTES / BYTES_PER_WORD;
  localparam int WIP_W          = $clog2(WORDS_PER_PKT);
  localparam int PKT_W          = (ADDR_W > WIP_W) ? ADDR_W - WIP_W : 1;

  logic [WORD_W-1:0] binMem [DEPTH];

  always_ff @(posedge sampleClk) begin
    if (wrEn) binMem[wrAddr] <= wrData;
  end

  logic [BYTE_IDX_W-1:0] byteIdx, byteIdxNext;
  logic [PKT_W-1:0]      pktIdx, pktIdxNext;
  logic [ADDR_W-1:0]     rdAddr;
  logic [WORD_W-1:0]     rdWord;
  logic                  padReg, padNext;
  logic                  atLastByte;
  logic [CNT_W:0]        wordsThrough;

  assign atLastByte = &byteIdx;

  always_comb begin
    byteIdxNext = byteIdx;
    pktIdxNext  = pktIdx;
    if (strobe.load) begin
      byteIdxNext = '0;
      pktIdxNext  = '0;
    end else if (strobe.advance) begin
      byteIdxNext = byteIdx + 1'b1;
      if (atLastByte) pktIdxNext = pktIdx + 1'b1;
    end
  end

  // read address follows the index the counters will hold next cycle,
  // so the registered word is in step with the byte counter
  assign rdAddr  = ADDR_W'({pktIdxNext, byteIdxNext[BYTE_IDX_W-1:LANE_W]});
  assign padNext = {1'b0, rdAddr} >= cfgCount;

  always_ff @(posedge netClk) begin
    if (netRst) begin
      byteIdx <= '0;
      pktIdx  <= '0;
      padReg  <= 1'b1;
    end else begin
      byteIdx <= byteIdxNext;
      pktIdx  <= pktIdxNext;
      padReg  <= padNext;
    end
  end

  always_ff @(posedge netClk) begin
    rdWord <= binMem[rdAddr];
  end

  assign byteOut = padReg ? 8'h00 : rdWord[{byteIdx[LANE_W-1:0], 3'b000} +: 8];

  assign wordsThrough   = (CNT_W+1)'({pktIdx, {WIP_W{1'b0}}}) + (CNT_W+1)'(WORDS_PER_PKT);
  assign status.lastByte = atLastByte;
  assign status.lastPkt  = wordsThrough >= {1'b0, cfgCount};
  assign status.noWords  = (cfgCount == '0);
endmodule

// File: rtl/bpk_control.sv
`timescale 1ns/1ps
module bpk_control
  import bpk_pkg::*;
(
  input  logic       netClk,
  input  logic       netRst,
  input  logic       startSeen,
  input  bpkStatus_t status,
  input  logic       reqReady,
  input  logic       mTready,
  output bpkStrobe_t strobe,
  output logic       sendReq,
  output logic       mTvalid,
  output logic       doneTog
);
  bpkState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (startSeen) begin
        strobe.load = 1'b1;
        stateNext   = status.noWords ? ST_FIN : ST_REQ;
      end
      ST_REQ: if (reqReady) stateNext = ST_SEND;
      ST_SEND: if (mTready) begin
        strobe.advance = 1'b1;
        if (status.lastByte) stateNext = status.lastPkt ? ST_FIN : ST_REQ;
      end
      ST_FIN: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge netClk) begin
    if (netRst) begin
      state   <= ST_IDLE;
      doneTog <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_FIN) doneTog <= ~doneTog;
    end
  end

  assign sendReq = (state == ST_REQ);
  assign mTvalid = (state == ST_SEND);
endmodule

// File: rtl/byte_packetizer.sv
`timescale 1ns/1ps
module byte_packetizer
  import bpk_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int PKT_BYTES   = 1024,
  parameter int DEPTH       = 1024,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int CNT_W      = ADDR_W + 1
) (
  input  logic              sampleClk,
  input  logic              sampleRst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              startPulse,
  input  logic [CNT_W-1:0]  wordCount,
  output logic              allSent,
  input  logic              netClk,
  input  logic              netRst,
  output logic              sendReq,
  input  logic              reqReady,
  output logic [7:0]        mTdata,
  output logic              mTvalid,
  input  logic              mTready,
  output logic              mTlast
);
  logic             busy, startTog, doneTog, startSeen, doneSeen;
  logic [CNT_W-1:0] cfgCount;
  bpkStrobe_t       strobe;
  bpkStatus_t       status;

  // sample side: capture the count, flip the start toggle, lock out until done
  always_ff @(posedge sampleClk) begin
    if (sampleRst) begin
      busy     <= 1'b0;
      startTog <= 1'b0;
      cfgCount <= '0;
    end else if (startPulse && !busy) begin
      busy     <= 1'b1;
      startTog <= ~startTog;
      cfgCount <= wordCount;
    end else if (doneSeen) begin
      busy <= 1'b0;
    end
  end

  assign allSent = doneSeen;

  bpk_toggle_sync #(.SYNC_STAGES(SYNC_STAGES)) startSync (
    .dstClk(netClk), .dstRst(netRst), .srcTog(startTog), .edgePulse(startSeen));

  bpk_toggle_sync #(.SYNC_STAGES(SYNC_STAGES)) doneSync (
    .dstClk(sampleClk), .dstRst(sampleRst), .srcTog(doneTog), .edgePulse(doneSeen));

  bpk_control ctrl (
    .netClk(netClk), .netRst(netRst), .startSeen(startSeen), .status(status),
    .reqReady(reqReady), .mTready(mTready), .strobe(strobe),
    .sendReq(sendReq), .mTvalid(mTvalid), .doneTog(doneTog));

  bpk_datapath #(.WORD_W(WORD_W), .PKT_BYTES(PKT_BYTES), .DEPTH(DEPTH)) dpath (
    .sampleClk(sampleClk), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .netClk(netClk), .netRst(netRst), .strobe(strobe), .cfgCount(cfgCount),
    .status(status), .byteOut(mTdata));

  assign mTlast = mTvalid && status.lastByte;
endmodule

// File: rtl/bpk_checker.sv
`timescale 1ns/1ps
module bpk_checker (
  input logic       netClk,
  input logic       netRst,
  input logic       sampleClk,
  input logic       sampleRst,
  input logic       sendReq,
  input logic       reqReady,
  input logic [7:0] mTdata,
  input logic       mTvalid,
  input logic       mTready,
  input logic       mTlast,
  input logic       allSent
);
  AST_STALL_HOLD: assert property (@(posedge netClk) disable iff (netRst)
    (mTvalid && !mTready) |=> (mTvalid && $stable(mTdata) && $stable(mTlast))); // R6

  AST_REQ_HOLD: assert property (@(posedge netClk) disable iff (netRst)
    (sendReq && !reqReady) |=> sendReq); // R7

  AST_REQ_EXCL: assert property (@(posedge netClk) disable iff (netRst)
    !(sendReq && mTvalid)); // R7

  AST_VALID_AFTER_ACK: assert property (@(posedge netClk) disable iff (netRst)
    $rose(mTvalid) |-> $past(sendReq && reqReady)); // R7

  AST_LAST_WITH_VALID: assert property (@(posedge netClk) disable iff (netRst)
    mTlast |-> mTvalid); // R3

  AST_DONE_PULSE: assert property (@(posedge sampleClk) disable iff (sampleRst)
    allSent |=> !allSent); // R8
endmodule

bind byte_packetizer bpk_checker chk (
  .netClk(netClk), .netRst(netRst), .sampleClk(sampleClk), .sampleRst(sampleRst),
  .sendReq(sendReq), .reqReady(reqReady), .mTdata(mTdata), .mTvalid(mTvalid),
  .mTready(mTready), .mTlast(mTlast), .allSent(allSent));

// File: tb/byte_packetizer_test.sv
`timescale 1ns/1ps
module byte_packetizer_test;
  localparam int DEPTH     = 1024;
  localparam int PKT_BYTES = 1024;
  localparam int WPP       = 256;
  localparam int NVEC      = 5;
  // count, mTready pattern (8 cycles, LSB first), request-to-ready delay
  localparam int VEC [NVEC][3] = '{
    '{256,  255, 0},
    '{1,    255, 3},
    '{300,  182, 2},
    '{513,   85, 1},
    '{1024, 125, 4}
  };

  logic        sampleClk = 0, netClk = 0;
  logic        sampleRst, netRst;
  logic        wrEn = 0;
  logic [9:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        startPulse = 0;
  logic [10:0] wordCount = '0;
  logic        allSent, sendReq, mTvalid, mTlast;
  logic        reqReady = 0, mTready = 0;
  logic [7:0]  mTdata;

  always #2.5 netClk = ~netClk;
  always #3.5 sampleClk = ~sampleClk;

  byte_packetizer uut (
    .sampleClk(sampleClk), .sampleRst(sampleRst), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .startPulse(startPulse), .wordCount(wordCount), .allSent(allSent),
    .netClk(netClk), .netRst(netRst), .sendReq(sendReq), .reqReady(reqReady),
    .mTdata(mTdata), .mTvalid(mTvalid), .mTready(mTready), .mTlast(mTlast));

  int nChecks = 0, nBad = 0;
  int curCount = 0, reqDelay = 0, reqWait = 0, cyc = 0;
  logic [7:0] readyPat = 8'hFF;
  int pktSeen, byteOff, bytesTotal, dataErr, padErr, lastErr, stallErr, reqErr;
  int reqRaised, doneCnt, doneBytes;
  logic reqSeen, prevStall, prevLast;
  logic [7:0] prevData;

  function automatic logic [31:0] wordVal(input int i);
    logic [31:0] v;
    v = 32'h9E3779B9 * 32'(i + 1);
    return v ^ 32'(i);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clearScore;
    pktSeen = 0; byteOff = 0; bytesTotal = 0; dataErr = 0; padErr = 0;
    lastErr = 0; stallErr = 0; reqErr = 0; reqRaised = 0; doneCnt = 0;
    doneBytes = -1; reqSeen = 0; prevStall = 0; prevLast = 0; prevData = '0;
  endtask

  // stream monitor, sampled between edges
  always @(negedge netClk) begin
    if (!netRst) begin
      if (prevStall && (!mTvalid || mTdata !== prevData || mTlast !== prevLast)) stallErr++;
      if (mTvalid && !reqSeen) reqErr++;
      if (sendReq && mTvalid) reqErr++;
      if (sendReq) reqRaised++;
      if (sendReq && reqReady) reqSeen = 1;
      if (mTvalid && mTready) begin
        automatic int widx = pktSeen * WPP + byteOff / 4;
        automatic logic [31:0] w = wordVal(widx);
        if (widx >= curCount) begin
          if (mTdata !== 8'h00) padErr++;
        end else if (mTdata !== w[8*(byteOff%4) +: 8]) dataErr++;
        if (mTlast !== (byteOff == PKT_BYTES - 1)) lastErr++;
        bytesTotal++;
        if (byteOff == PKT_BYTES - 1) begin
          byteOff = 0; pktSeen++; reqSeen = 0;
        end else byteOff++;
      end
      prevStall = mTvalid && !mTready;
      prevData  = mTdata;
      prevLast  = mTlast;
    end
  end

  always @(negedge sampleClk) begin
    if (!sampleRst && allSent) begin
      doneCnt++;
      doneBytes = bytesTotal;
    end
  end

  // consumer model: backpressure pattern and delayed acknowledge
  always @(posedge netClk) begin
    cyc++;
    #1;
    mTready = readyPat[cyc % 8];
    if (sendReq) begin
      if (reqWait >= reqDelay) reqReady = 1;
      reqWait++;
    end else begin
      reqReady = 0;
      reqWait  = 0;
    end
  end

  task automatic startRun(input int count);
    @(posedge sampleClk); #1;
    wordCount  = 11'(count);
    startPulse = 1;
    @(posedge sampleClk); #1;
    startPulse = 0;
  endtask

  task automatic waitDone(input int limit);
    int n = 0;
    while (doneCnt == 0 && n < limit) begin
      @(posedge netClk);
      n++;
    end
    chk("watchdog (run finished)", int'(doneCnt != 0), 1);
    repeat (40) @(posedge netClk);
  endtask

  task automatic checkRun(input int count);
    int np = (count + WPP - 1) / WPP;
    chk("R2 packet count", pktSeen, np);
    chk("R2 byte count", bytesTotal, np * PKT_BYTES);
    chk("R3 tlast placement errors", lastErr, 0);
    chk("R4 byte order errors", dataErr, 0);
    chk("R5 padding errors", padErr, 0);
    chk("R6 stall errors", stallErr, 0);
    chk("R7 handshake errors", reqErr, 0);
    chk("R8 done pulses", doneCnt, 1);
    chk("R8 bytes before done", doneBytes, np * PKT_BYTES);
  endtask

  initial begin
    #900000;
    nChecks++; nBad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    clearScore();
    sampleRst = 1; netRst = 1;
    repeat (6) @(posedge sampleClk);
    @(negedge netClk);
    chk("R1 mTvalid in reset", int'(mTvalid), 0);
    chk("R1 sendReq in reset", int'(sendReq), 0);
    #1; sampleRst = 0; netRst = 0;
    repeat (3) @(posedge sampleClk);
    @(negedge netClk);
    chk("R1 mTvalid after reset", int'(mTvalid), 0);
    chk("R1 mTlast after reset", int'(mTlast), 0);
    chk("R1 sendReq after reset", int'(sendReq), 0);
    chk("R1 allSent after reset", int'(allSent), 0);

    for (int i = 0; i < DEPTH; i++) begin
      @(posedge sampleClk); #1;
      wrEn = 1; wrAddr = 10'(i); wrData = wordVal(i);
    end
    @(posedge sampleClk); #1; wrEn = 0;

    for (int v = 0; v < NVEC; v++) begin
      clearScore();
      curCount = VEC[v][0];
      readyPat = 8'(VEC[v][1]);
      reqDelay = VEC[v][2];
      startRun(curCount);
      waitDone(30000);
      checkRun(curCount);
    end

    // R9: empty transfer
    clearScore();
    curCount = 0; readyPat = 8'hFF; reqDelay = 0;
    startRun(0);
    waitDone(2000);
    chk("R9 packets for zero count", pktSeen, 0);
    chk("R9 sendReq cycles for zero count", reqRaised, 0);
    chk("R9 done pulses for zero count", doneCnt, 1);

    // R10: second start during a transfer is dropped
    clearScore();
    curCount = 300; readyPat = 8'hFF; reqDelay = 1;
    startRun(300);
    repeat (300) @(posedge netClk);
    startRun(5);
    waitDone(30000);
    checkRun(300);
    repeat (200) @(posedge netClk);
    chk("R10 packets after ignored start", pktSeen, 2);
    chk("R10 done pulses after ignored start", doneCnt, 1);

    // R11: count changed after the start has no effect
    clearScore();
    curCount = 600; readyPat = 8'hEF; reqDelay = 0;
    startRun(600);
    @(posedge sampleClk); #1; wordCount = 11'd0;
    waitDone(30000);
    checkRun(600);
    chk("R11 packets with count changed later", pktSeen, 3);

    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end
endmodule